// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervision counter that asks for a system reset when software stops servicing it. It runs either on a slow low-power tick of roughly 1 kHz, delivered as a one-cycle enable inside the bus-clock domain, or directly on the bus clock. Software picks one of three timeout lengths with a 2-bit select, or turns the counter off with the value 0.

The clock-source choice and the window enable sit in a configuration register that can be set once after reset. Later writes still change the timeout select, but they leave those two fields alone. With the bus clock as source and the window enabled, a service is accepted only in the last quarter of the period. A service that arrives earlier is treated as a fault and raises the reset request at once. With the slow tick as source, the window setting has no effect.

The reset request is a registered single-cycle pulse. It is raised on overflow or on an early service. Logic outside the block turns that pulse into the actual system reset.

Top module: `wdog_top`

## Requirements
- R1: After `rst_n` is released, `rst_req` is 0, the source is the slow tick, the window is off, the select is 3 and the lock is clear. The bus clock alone therefore never causes a request, and the request fires after 2^SLOW_EXP[2] ticks.
- R2: A select value of 0 disables the counter for either source. `rst_req` stays 0 whatever `svc` does, even when the window is enabled.
- R3: With `cfg_src_bus`=0 the count advances only in cycles where `tick_en`=1. Select values 1, 2 and 3 give an overflow after 2^SLOW_EXP[0], 2^SLOW_EXP[1] and 2^SLOW_EXP[2] ticks.
- R4: With `cfg_src_bus`=1 the count advances on every cycle. Select values 1, 2 and 3 give an overflow after 2^BUS_EXP[0], 2^BUS_EXP[1] and 2^BUS_EXP[2] cycles, counted from the last accepted config write or service.
- R5: On overflow, `rst_req` is high for exactly one cycle, the cycle after the edge that reaches the count. The count then restarts from zero, so the next overflow follows one full period later.
- R6: Outside window mode, a `svc` pulse while enabled clears the count, which delays the next overflow by a full period.
- R7: With the bus source and the window on, a `svc` seen while the count is below 3/4 of the period (for example 24 of 32) raises `rst_req` in the next cycle and clears the count.
- R8: With the bus source and the window on, a `svc` seen at a count of 3/4 of the period or more is accepted like a normal service.
- R9: With the slow source, the window bit has no effect, and a `svc` at count 0 is accepted.
- R10: The first `cfg_we` after reset loads all fields and sets the lock. Later writes update only the select and leave the source and window fields unchanged. Every write clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle enable for the slow tick |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Timeout select (0 = off) |
| cfg_src_bus | input | 1 | 1 = bus clock source, 0 = slow tick (write-once) |
| cfg_win | input | 1 | Window enable (write-once) |
| svc | input | 1 | Service strobe |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The counter, the lock and the latched fields are all internal, but any error in them changes when `rst_req` appears. A wrong count or a wrong period moves the overflow pulse by at least one cycle from its expected edge. A wrong window threshold turns a service at the edge of the window into a request, or the other way round, within one cycle. A lock that fails to hold lets a later write turn the window off, so the next early service no longer produces a request. For that reason every scenario predicts the exact cycle of each pulse and checks `rst_req` one cycle before, on, and after that cycle.

// File: rtl/wdog_pkg.sv
// Package: shared types and helpers for the windowed watchdog.
// Assumes three timeout entries per clock source, indexed by select-1.
package wdog_pkg;
    typedef int unsigned exp_tab_t [3];

    typedef struct packed {
        logic [1:0] sel;
        logic       src_bus;
        logic       win;
    } wdog_cfg_t;

    // Largest exponent in a table
    function automatic int unsigned tab_max(exp_tab_t t);
        int unsigned m = 0;
        for (int i = 0; i < 3; i++) if (t[i] > m) m = t[i];
        return m;
    endfunction
endpackage

// File: rtl/wdog_cfg.sv
// Write-once configuration holder. The select is writable at any time.
// Source and window load only on the first write after reset.
// Assumes writes are single-cycle strobes in the bus-clock domain.
module wdog_cfg
    import wdog_pkg::*;
#(
    parameter logic [1:0] SEL_RST = 2'b11
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  wdog_cfg_t wr_cfg,
    output wdog_cfg_t cfg_q,
    output logic      lock_q
);
    // Load fields and set the lock on the first write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.sel     <= SEL_RST;
            cfg_q.src_bus <= 1'b0;
            cfg_q.win     <= 1'b0;
            lock_q        <= 1'b0;
        end else if (wr_en) begin
            cfg_q.sel <= wr_cfg.sel;
            if (!lock_q) begin
                cfg_q.src_bus <= wr_cfg.src_bus;
                cfg_q.win     <= wr_cfg.win;
                lock_q        <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdog_limits.sv
// Turns the configuration into a terminal count and a window-open count.
// Assumes every exponent is at least 2 and no larger than CNT_W.
module wdog_limits
    import wdog_pkg::*;
#(
    parameter exp_tab_t SLOW_EXP = '{5, 8, 10},
    parameter exp_tab_t BUS_EXP  = '{13, 16, 18},
    parameter int unsigned CNT_W = 18
) (
    input  wdog_cfg_t        cfg,
    output logic             enable,
    output logic             win_act,
    output logic [CNT_W-1:0] term,
    output logic [CNT_W-1:0] open_cnt
);
    logic [CNT_W-1:0] slow_term [3];
    logic [CNT_W-1:0] bus_term  [3];
    logic [CNT_W-1:0] bus_open  [3];

    // Build one table entry per select value
    for (genvar g = 0; g < 3; g++) begin : g_tab
        localparam longint unsigned SLEN = 64'd1 << SLOW_EXP[g];
        localparam longint unsigned BLEN = 64'd1 << BUS_EXP[g];
        assign slow_term[g] = CNT_W'(SLEN - 64'd1);
        assign bus_term[g]  = CNT_W'(BLEN - 64'd1);
        assign bus_open[g]  = CNT_W'(BLEN - BLEN / 64'd4);
    end

    // Pick the entry for the current select and source
    always_comb begin
        enable   = 1'b1;
        term     = '0;
        open_cnt = '0;
        case (cfg.sel)
            2'd1: begin
                term     = cfg.src_bus ? bus_term[0] : slow_term[0];
                open_cnt = bus_open[0];
            end
            2'd2: begin
                term     = cfg.src_bus ? bus_term[1] : slow_term[1];
                open_cnt = bus_open[1];
            end
            2'd3: begin
                term     = cfg.src_bus ? bus_term[2] : slow_term[2];
                open_cnt = bus_open[2];
            end
            default: enable = 1'b0;
        endcase
        win_act = enable && cfg.src_bus && cfg.win;
    end
endmodule

// File: rtl/wdog_counter.sv
// Timeout counter with service and window checking. Produces a registered
// one-cycle request. Assumes term and open_cnt are steady while enabled.
module wdog_counter #(
    parameter int unsigned CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             src_bus,
    input  logic             tick_en,
    input  logic             svc,
    input  logic             load,
    input  logic             win_act,
    input  logic [CNT_W-1:0] term,
    input  logic [CNT_W-1:0] open_cnt,
    output logic [CNT_W-1:0] cnt_q,
    output logic             fire_q
);
    logic [CNT_W-1:0] cnt_d;
    logic             fire_d;
    logic             adv;

    // Next count and request decision
    always_comb begin
        adv    = src_bus || tick_en;
        cnt_d  = cnt_q;
        fire_d = 1'b0;
        if (!enable || load) begin
            cnt_d = '0;
        end else if (svc) begin
            cnt_d  = '0;
            fire_d = win_act && (cnt_q < open_cnt);
        end else if (adv) begin
            if (cnt_q == term) begin
                cnt_d  = '0;
                fire_d = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    // Hold the count and the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            fire_q <= fire_d;
        end
    end
endmodule

// File: rtl/wdog_top.sv
// Windowed watchdog top: config holder, limit decode and counter.
// Assumes tick_en is already synchronous to clk and one cycle wide.
module wdog_top
    import wdog_pkg::*;
#(
    parameter exp_tab_t SLOW_EXP = '{5, 8, 10},
    parameter exp_tab_t BUS_EXP  = '{13, 16, 18},
    parameter logic [1:0] SEL_RST = 2'b11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       cfg_we,
    input  logic [1:0] cfg_sel,
    input  logic       cfg_src_bus,
    input  logic       cfg_win,
    input  logic       svc,
    output logic       rst_req
);
    localparam int unsigned SMAX  = tab_max(SLOW_EXP);
    localparam int unsigned BMAX  = tab_max(BUS_EXP);
    localparam int unsigned CNT_W = (SMAX > BMAX) ? SMAX : BMAX;

    wdog_cfg_t        wr_cfg;
    wdog_cfg_t        cfg_q;
    logic             lock_q;
    logic             enable;
    logic             win_act;
    logic [CNT_W-1:0] term;
    logic [CNT_W-1:0] open_cnt;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       sel_q;
    logic             src_q;
    logic             win_q;

    // Gather write fields into one word
    always_comb begin
        wr_cfg.sel     = cfg_sel;
        wr_cfg.src_bus = cfg_src_bus;
        wr_cfg.win     = cfg_win;
    end

    assign sel_q = cfg_q.sel;
    assign src_q = cfg_q.src_bus;
    assign win_q = cfg_q.win;

    wdog_cfg #(.SEL_RST(SEL_RST)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_cfg(wr_cfg),
        .cfg_q(cfg_q), .lock_q(lock_q)
    );

    wdog_limits #(.SLOW_EXP(SLOW_EXP), .BUS_EXP(BUS_EXP), .CNT_W(CNT_W)) lim_i (
        .cfg(cfg_q), .enable(enable), .win_act(win_act),
        .term(term), .open_cnt(open_cnt)
    );

    wdog_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .src_bus(src_q),
        .tick_en(tick_en), .svc(svc), .load(cfg_we), .win_act(win_act),
        .term(term), .open_cnt(open_cnt), .cnt_q(cnt_q), .fire_q(rst_req)
    );
endmodule

// File: rtl/wdog_chk.sv
// Property checker bound to wdog_top; observes config state and count.
module wdog_chk #(
    parameter int unsigned CNT_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             cfg_we,
    input logic             svc,
    input logic             rst_req,
    input logic [1:0]       sel_q,
    input logic             src_q,
    input logic             win_q,
    input logic             lock_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] term,
    input logic [CNT_W-1:0] open_cnt
);
    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 2'd0) |=> !rst_req);

    p_slow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_q && !tick_en && !svc && !cfg_we && sel_q != 2'd0) |=> $stable(cnt_q));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != 2'd0) |-> (cnt_q <= term));

    p_svc_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (svc && sel_q != 2'd0) |=> (cnt_q == '0));

    p_early_svc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (svc && !cfg_we && sel_q != 2'd0 && src_q && win_q && cnt_q < open_cnt) |=> rst_req);

    p_lock_sticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> (lock_q && $stable(src_q) && $stable(win_q)));
endmodule

bind wdog_top wdog_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_we(cfg_we), .svc(svc),
    .rst_req(rst_req), .sel_q(sel_q), .src_q(src_q), .win_q(win_q),
    .lock_q(lock_q), .cnt_q(cnt_q), .term(term), .open_cnt(open_cnt)
);

// File: tb/wdog_top_tb_top.sv
// Directed bench. Short tables: slow 4/8/16 ticks, bus 32/64/128 cycles.
module wdog_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic       cfg_src_bus = 1'b0;
    logic       cfg_win = 1'b0;
    logic       svc = 1'b0;
    logic       rst_req;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    wdog_top #(.SLOW_EXP('{2, 3, 4}), .BUS_EXP('{5, 6, 7})) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_src_bus(cfg_src_bus), .cfg_win(cfg_win),
        .svc(svc), .rst_req(rst_req)
    );

    task automatic chk(input logic exp, input string req);
        n_chk++;
        if (rst_req !== exp) begin
            n_bad++;
            $display("FAIL %s: rst_req=%b expected %b at %0t", req, rst_req, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] s, input logic b, input logic w);
        cfg_we = 1'b1; cfg_sel = s; cfg_src_bus = b; cfg_win = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_svc();
        svc = 1'b1;
        @(negedge clk);
        svc = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    // Predicts an overflow exactly len edges from now
    task automatic expect_fire(input int len, input string req);
        idle(len - 1);
        chk(1'b0, req);
        idle(1);
        chk(1'b1, req);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(1'b0, "R1");
        idle(200);
        chk(1'b0, "R1");
        ticks(15);
        chk(1'b0, "R1");
        ticks(1);
        chk(1'b1, "R1");
    endtask

    task automatic t_disabled();
        do_reset();
        wr(2'd0, 1'b1, 1'b1);
        idle(300);
        chk(1'b0, "R2");
        pulse_svc();
        chk(1'b0, "R2");
        wr(2'd1, 1'b0, 1'b0);
        expect_fire(32, "R2");
    endtask

    task automatic t_slow();
        do_reset();
        wr(2'd2, 1'b0, 1'b0);
        idle(100);
        chk(1'b0, "R3");
        ticks(7);
        chk(1'b0, "R3");
        ticks(1);
        chk(1'b1, "R3");
    endtask

    task automatic t_bus();
        do_reset();
        wr(2'd1, 1'b1, 1'b0);
        expect_fire(32, "R4");
        idle(1);
        chk(1'b0, "R5");
        expect_fire(31, "R5");
        wr(2'd2, 1'b0, 1'b0);
        expect_fire(64, "R4");
        wr(2'd3, 1'b0, 1'b0);
        expect_fire(128, "R4");
    endtask

    task automatic t_service();
        do_reset();
        wr(2'd1, 1'b1, 1'b0);
        idle(20);
        pulse_svc();
        chk(1'b0, "R6");
        expect_fire(32, "R6");
    endtask

    task automatic t_window();
        do_reset();
        wr(2'd1, 1'b1, 1'b1);
        idle(10);
        pulse_svc();
        chk(1'b1, "R7");
        wr(2'd1, 1'b1, 1'b1);
        idle(23);
        pulse_svc();
        chk(1'b1, "R7");
        wr(2'd1, 1'b1, 1'b1);
        idle(24);
        pulse_svc();
        chk(1'b0, "R8");
        expect_fire(32, "R8");
    endtask

    task automatic t_slow_window();
        do_reset();
        wr(2'd1, 1'b0, 1'b1);
        pulse_svc();
        chk(1'b0, "R9");
        ticks(3);
        chk(1'b0, "R9");
        ticks(1);
        chk(1'b1, "R9");
    endtask

    task automatic t_lock();
        do_reset();
        wr(2'd1, 1'b1, 1'b1);
        wr(2'd1, 1'b0, 1'b0);
        idle(5);
        pulse_svc();
        chk(1'b1, "R10");
        wr(2'd2, 1'b0, 1'b0);
        expect_fire(64, "R10");
    endtask

    initial begin
        t_reset_state();
        t_disabled();
        t_slow();
        t_bus();
        t_service();
        t_window();
        t_slow_window();
        t_lock();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule